// File: doc/BRIEF.md
# Configurable Byte-Order Swap Unit

This unit executes the endianness-conversion operation of a 64-bit register virtual machine. The operation touches only the destination register. It reads that register's value and produces a new value for it. No source register and no immediate data operand take part. The immediate field carries only the swap width.

The caller supplies four things for each operation:
- the ALU class, 32-bit or 64-bit;
- the single order-select bit taken from the opcode;
- the width immediate;
- the current destination value.

Host byte order is fixed when the block is built. One clock edge after an accepted operation, the unit presents the new register value, a valid strobe and a flag marking an illegal encoding. Instruction fetch and register write-back belong to the surrounding pipeline.

Top module: `byte_order_unit`

## Requirements
- R1: `resValid` is high in exactly the cycle after a cycle in which `inValid` was high, so the latency is one clock edge.
- R2: In the 32-bit class (`isAlu64`=0), `orderSel`=0 requests little endian. On a little-endian host, the low `widthImm` bits of `dstIn` pass through unchanged.
- R3: In the 32-bit class, `orderSel`=1 requests big endian. On a little-endian host, the bytes of the low `widthImm` bits are reversed: result byte i comes from input byte (N-1-i), where N = width/8.
- R4: In the 64-bit class (`isAlu64`=1) with `orderSel`=0, the bytes of the low width bits are always reversed, whatever the host byte order.
- R5: Only widths 16, 32 and 64 are legal. For any other `widthImm` value, `illegal` rises together with `resValid` and `result` is zero.
- R6: In the 64-bit class, `orderSel`=1 is a reserved encoding. It raises `illegal` and gives a zero `result`.
- R7: For a legal width below 64, every result bit at or above the width is zero.
- R8: With `HOST_BIG`=1, the 32-bit class passes data through for `orderSel`=1 and reverses bytes for `orderSel`=0. The 64-bit class behaves the same as on a little-endian host.
- R9: A cycle with `inValid` low leaves `result` unchanged in the next cycle, with `resValid` and `illegal` low.
- R10: While `rst_n` is low, `resValid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| isAlu64 | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| orderSel | input | 1 | Opcode order bit: 0 = little endian, 1 = big endian |
| widthImm | input | 32 | Swap width in bits |
| dstIn | input | 64 | Current destination register value |
| result | output | 64 | New destination value |
| resValid | output | 1 | Result strobe |
| illegal | output | 1 | Illegal encoding for the operation just reported |

## Verification
Every output is due exactly one rising edge after the cycle in which the operation was presented: the result value, the valid strobe and the illegal flag. The hold behaviour on idle cycles falls due at the same edge. The bench drives inputs on the falling edge and compares all outputs at the next falling edge against a behavioural model. That model reverses bytes with integer loops and remembers the last produced value for idle cycles. Two instances are checked side by side, one for each host byte order.

// File: rtl/byte_order_pkg.sv
package byte_order_pkg;
  localparam int DATA_W = 64;
  localparam int IMM_W = 32;
  localparam int NUM_LANES = $clog2(DATA_W / 8);

  typedef struct packed {
    logic doSwap;
    logic badCode;
    logic [NUM_LANES-1:0] laneSel;
  } swapCtl_t;
endpackage

// File: rtl/byte_order_ctrl.sv
module byte_order_ctrl
  import byte_order_pkg::*;
#(
  parameter bit HOST_BIG = 1'b0
) (
  input  logic             isAlu64,
  input  logic             orderSel,
  input  logic [IMM_W-1:0] widthImm,
  output swapCtl_t         ctl
);
  logic [NUM_LANES-1:0] widthHit;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gHit
    assign widthHit[g] = (widthImm == IMM_W'(16 << g));
  end

  always_comb begin
    ctl.laneSel = widthHit;
    ctl.doSwap  = isAlu64 | (orderSel != HOST_BIG);
    ctl.badCode = (widthHit == '0) | (isAlu64 & orderSel);
  end
endmodule

// File: rtl/byte_order_dp.sv
module byte_order_dp
  import byte_order_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  swapCtl_t          ctl,
  input  logic [DATA_W-1:0] dstIn,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              illegal
);
  logic [DATA_W-1:0] swapLane [NUM_LANES];
  logic [DATA_W-1:0] passLane [NUM_LANES];
  logic [DATA_W-1:0] nextRes;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int NB = 2 << g;
    logic [DATA_W-1:0] sw;
    always_comb begin
      sw = '0;
      for (int b = 0; b < NB; b++) sw[b*8 +: 8] = dstIn[(NB-1-b)*8 +: 8];
    end
    assign swapLane[g] = sw;
    assign passLane[g] = DATA_W'(dstIn[NB*8-1:0]);
  end

  always_comb begin
    nextRes = '0;
    for (int g = 0; g < NUM_LANES; g++)
      if (ctl.laneSel[g]) nextRes |= ctl.doSwap ? swapLane[g] : passLane[g];
    if (ctl.badCode) nextRes = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= inValid;
      illegal  <= inValid & ctl.badCode;
      if (inValid) result <= nextRes;
    end
  end
endmodule

// File: rtl/byte_order_unit.sv
module byte_order_unit
  import byte_order_pkg::*;
#(
  parameter bit HOST_BIG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              isAlu64,
  input  logic              orderSel,
  input  logic [IMM_W-1:0]  widthImm,
  input  logic [DATA_W-1:0] dstIn,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              illegal
);
  swapCtl_t ctl;

  byte_order_ctrl #(.HOST_BIG(HOST_BIG)) uCtrl (
    .isAlu64(isAlu64), .orderSel(orderSel), .widthImm(widthImm), .ctl(ctl)
  );

  byte_order_dp uDp (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .ctl(ctl), .dstIn(dstIn),
    .result(result), .resValid(resValid), .illegal(illegal)
  );
endmodule

// File: rtl/byte_order_unit_chk.sv
module byte_order_unit_chk
  import byte_order_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              isAlu64,
  input logic              orderSel,
  input logic [IMM_W-1:0]  widthImm,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              illegal
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> resValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !resValid);
  assert_bad_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && widthImm != 16 && widthImm != 32 && widthImm != 64) |=> (illegal && result == '0));
  assert_reserved_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isAlu64 && orderSel) |=> (illegal && result == '0));
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && widthImm == 16) |=> (result[DATA_W-1:16] == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(result) && !illegal));
endmodule

bind byte_order_unit byte_order_unit_chk uChk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .isAlu64(isAlu64),
  .orderSel(orderSel), .widthImm(widthImm), .result(result),
  .resValid(resValid), .illegal(illegal)
);

// File: tb/byte_order_unit_test.sv
module byte_order_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, isAlu64 = 1'b0, orderSel = 1'b0;
  logic [31:0] widthImm = '0;
  logic [63:0] dstIn = '0;
  logic [63:0] resLe, resBe;
  logic validLe, validBe, illLe, illBe;

  int applied = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_order_unit #(.HOST_BIG(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isAlu64(isAlu64),
    .orderSel(orderSel), .widthImm(widthImm), .dstIn(dstIn),
    .result(resLe), .resValid(validLe), .illegal(illLe)
  );
  byte_order_unit #(.HOST_BIG(1'b1)) uutBe (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isAlu64(isAlu64),
    .orderSel(orderSel), .widthImm(widthImm), .dstIn(dstIn),
    .result(resBe), .resValid(validBe), .illegal(illBe)
  );

  logic [63:0] expRes [2];
  logic expValid = 1'b0, expIll = 1'b0, expSmall = 1'b0;
  string expTag [2];

  initial begin expRes[0] = '0; expRes[1] = '0; expTag[0] = "R9"; expTag[1] = "R9"; end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(bit a64, bit ord, logic [31:0] imm,
                                        logic [63:0] d, bit hostBig);
    logic [63:0] r = '0;
    int nb;
    bit sw;
    if (!(imm == 16 || imm == 32 || imm == 64) || (a64 && ord)) return '0;
    nb = imm / 8;
    sw = a64 || (ord != hostBig);
    for (int i = 0; i < nb; i++)
      r[i*8 +: 8] = sw ? d[(nb-1-i)*8 +: 8] : d[i*8 +: 8];
    return r;
  endfunction

  task automatic compare();
    check("R1", 64'(validLe), 64'(expValid));
    check("R1", 64'(validBe), 64'(expValid));
    check(expValid ? expTag[0] : "R9", 64'(illLe), 64'(expIll));
    check(expValid ? expTag[1] : "R9", 64'(illBe), 64'(expIll));
    check(expTag[0], resLe, expRes[0]);
    check(expTag[1], resBe, expRes[1]);
    if (expSmall) begin
      check("R7", 64'(resLe[63:16] == '0 || expRes[0][63:16] != '0), 64'd1);
    end
  endtask

  task automatic apply(bit v, bit a64, bit ord, logic [31:0] imm, logic [63:0] d);
    bit bad;
    @(negedge clk);
    compare();
    inValid = v; isAlu64 = a64; orderSel = ord; widthImm = imm; dstIn = d;
    bad = !(imm == 16 || imm == 32 || imm == 64) || (a64 && ord);
    expValid = v;
    expIll = v && bad;
    expSmall = v && !bad && imm == 16;
    for (int h = 0; h < 2; h++) begin
      if (v) begin
        expRes[h] = model(a64, ord, imm, d, h == 1);
        if (a64 && ord) expTag[h] = "R6";
        else if (bad) expTag[h] = "R5";
        else if (h == 1) expTag[h] = "R8";
        else if (a64) expTag[h] = "R4";
        else if (ord) expTag[h] = "R3";
        else expTag[h] = "R2";
      end else expTag[h] = "R9";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", resLe, 64'd0);
    check("R10", 64'({validLe, illLe, validBe, illBe}), 64'd0);
    rst_n = 1'b1;
    apply(1, 0, 0, 16, 64'h1122_3344_5566_7788);
    apply(1, 0, 1, 16, 64'h1122_3344_5566_7788);
    apply(1, 0, 0, 32, 64'h1122_3344_5566_7788);
    apply(1, 0, 1, 32, 64'h1122_3344_5566_7788);
    apply(1, 0, 1, 64, 64'h0102_0304_0506_0708);
    apply(1, 0, 0, 64, 64'h0102_0304_0506_0708);
    apply(1, 1, 0, 16, 64'hAABB_CCDD_EEFF_0011);
    apply(1, 1, 0, 32, 64'hAABB_CCDD_EEFF_0011);
    apply(1, 1, 0, 64, 64'hAABB_CCDD_EEFF_0011);
    apply(0, 0, 0, 64, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(0, 1, 1, 7, 64'h1234);
    apply(1, 1, 1, 64, 64'hDEAD_BEEF_0000_0001);
    apply(1, 0, 0, 8, 64'hDEAD_BEEF_0000_0001);
    apply(1, 1, 0, 48, 64'hDEAD_BEEF_0000_0001);
    apply(1, 0, 0, 0, 64'hDEAD_BEEF_0000_0001);
    apply(1, 0, 1, 16, 64'h8000_0000_0000_ABCD);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      case ($urandom_range(0, 4))
        0: w = 16; 1: w = 32; 2: w = 64; 3: w = $urandom_range(0, 80);
        default: w = $urandom;
      endcase
      apply(bit'($urandom_range(0, 3) != 0), bit'($urandom), bit'($urandom), w,
            {$urandom, $urandom});
    end
    apply(0, 0, 0, 0, 64'd0);
    apply(0, 0, 0, 0, 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule